// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block sits beside a serial receiver and watches three status conditions: a sync/hunt input pin, a break or abort level from the receiver, and a zero-count flag from a baud rate generator. While the latch is open, the status outputs follow those live conditions. When a qualifying change occurs, the latch closes and freezes a snapshot. If the source of the change is enabled, an interrupt request is raised. Software services the event and then pulses a reset command to reopen the latch.

Events that arrive while the latch is closed are not lost. A sync pin that has changed an odd number of times, a break that began or ended, and a zero count that is still present each make the latch close again straight after the reset command. A break that starts and ends during one closure always gives a start report and then an end report. The sync pin is asynchronous and goes through a synchronizer first. The break level and the zero-count flag are on-chip and are used as they arrive.

Top module: `ext_status_latch`

## Requirements
- R1: After reset, pend_o and irq_o are 0 and the status outputs follow their live inputs.
- R2: With the latch open, a change of the synchronized sync pin closes the latch on the next clock (pend_o=1), freezes stat_sync_o, and sets irq_o when en_sync_i=1.
- R3: While closed, sync pin changes have no visible effect. At the reset command, an odd net number of changes re-closes the latch with the new level and an interrupt when enabled. An even number lets the latch open.
- R4: mode_i encoding is 00 async, 01 external sync, 10 internal sync, 11 SDLC. In 01 and 10 the break level is treated as 0, so stat_brk_o reads 0 while the latch is open.
- R5: Either edge of the break level closes an open latch, with irq_o when en_brk_i=1. On a closed latch, an edge with en_brk_i=1 sets irq_o on the next clock even if it was 0.
- R6: A break start seen while closed makes the next reset command re-close the latch with stat_brk_o=1. A later break end makes the reset command after that re-close it with stat_brk_o=0.
- R7: A break start while closed cancels a stored break end. Any number of break sequences during one closure therefore produce exactly two re-closures: start, then end.
- R8: A rising zero-count flag closes an open latch and sets irq_o when en_zc_i=1. The zero-count bit is never frozen, so stat_zc_o follows the live flag even while closed.
- R9: A zero-count rise while closed raises no interrupt until the reset command. The command then re-closes the latch with an interrupt only if the flag is still 1.
- R10: stat_zc_o is 0 whenever en_zc_i=0.
- R11: When nothing is stored, the reset command on a closed latch clears pend_o and irq_o on the next clock. On an open latch it has no effect.
- R12: sync_pin_i passes through two flip-flops: stat_sync_o shows a pin change two clocks later, not one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Operating mode (see R4) |
| sync_pin_i | input | 1 | Asynchronous sync/hunt pin |
| brk_i | input | 1 | Break/abort level from the receiver |
| zc_i | input | 1 | Zero-count flag from the baud generator |
| en_sync_i | input | 1 | Interrupt enable, sync changes |
| en_brk_i | input | 1 | Interrupt enable, break/abort |
| en_zc_i | input | 1 | Interrupt enable and visibility, zero count |
| rst_latch_i | input | 1 | One-clock pulse reopening the latch |
| stat_sync_o | output | 1 | Sync status, live or frozen |
| stat_brk_o | output | 1 | Break/abort status, live or frozen |
| stat_zc_o | output | 1 | Zero-count status, always live |
| pend_o | output | 1 | Latch closed: a status change awaits service |
| irq_o | output | 1 | Interrupt request from an enabled source |

## Verification
The bench drives the sync pin twice while the latch is closed to check the parity rule. A design that counted edges instead of comparing net level would re-close after an even number of toggles. It runs break start/end/start sequences inside one closure: a design that kept the stored end would give a third re-closure, and one that dropped the start would never report a break at 1. It lets zero count rise and then fall before the reset command: a design that stored the rise alone would raise a stale interrupt. A table over all four modes checks that break stays at 0 in the two synchronous modes and that zero count is hidden when its enable is low.

// File: rtl/esl_pkg.sv
package esl_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC   = 2'b00,
        MODE_EXTSYNC = 2'b01,
        MODE_INTSYNC = 2'b10,
        MODE_SDLC    = 2'b11
    } esl_mode_e;

    // Frozen part of the status word (zero count is never frozen)
    typedef struct packed {
        logic sync;
        logic brk;
    } esl_snap_t;

    // Events seen in the current cycle
    typedef struct packed {
        logic sync_chg;
        logic brk_chg;
        logic zc_rise;
    } esl_evt_t;

    localparam int unsigned NUM_SRC = 3;

    function automatic logic brk_in_use(esl_mode_e m);
        return (m == MODE_ASYNC) || (m == MODE_SDLC);
    endfunction

    function automatic logic evt_irq(esl_evt_t e, logic es, logic eb, logic ez);
        return (e.sync_chg & es) | (e.brk_chg & eb) | (e.zc_rise & ez);
    endfunction

endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/esl_edge.sv
module esl_edge #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] prev_o
);
    always_ff @(posedge clk) begin
        if (rst) prev_o <= '0;
        else     prev_o <= live_i;
    end
endmodule

// File: rtl/esl_brk_store.sv
module esl_brk_store (
    input  logic clk,
    input  logic rst,
    input  logic closed_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic take_start_i,
    input  logic take_end_i,
    output logic start_o,
    output logic end_o
);
    logic start_q, end_q;

    // Current-cycle view including this cycle's edges
    always_comb begin
        start_o = start_q | (closed_i & rise_i);
        end_o   = end_q;
        if (closed_i && rise_i) end_o = 1'b0;
        else if (closed_i && fall_i) end_o = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !closed_i) begin
            start_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            start_q <= start_o & ~take_start_i;
            end_q   <= end_o & ~take_end_i;
        end
    end

    // R7: a start during closure wipes any stored end
    a_r7_start_cancels_end: assert property (@(posedge clk) disable iff (rst)
        (closed_i && rise_i) |=> !end_q);

endmodule

// File: rtl/ext_status_latch.sv
module ext_status_latch
    import esl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       sync_pin_i,
    input  logic       brk_i,
    input  logic       zc_i,
    input  logic       en_sync_i,
    input  logic       en_brk_i,
    input  logic       en_zc_i,
    input  logic       rst_latch_i,
    output logic       stat_sync_o,
    output logic       stat_brk_o,
    output logic       stat_zc_o,
    output logic       pend_o,
    output logic       irq_o
);
    localparam int unsigned IDX_SYNC = NUM_SRC - 1;
    localparam int unsigned IDX_BRK  = NUM_SRC - 2;
    localparam int unsigned IDX_ZC   = NUM_SRC - 3;

    esl_mode_e mode;
    logic      sync_live, brk_live, zc_live;
    logic [NUM_SRC-1:0] live_vec, prev_vec;
    esl_evt_t  evt;
    logic      brk_rise, brk_fall;

    logic      closed_q, closed_d;
    logic      irq_q, irq_d;
    logic      zc_seen_q, zc_seen_d, zc_seen_nx;
    esl_snap_t snap_q, snap_d, snap_live;
    logic      start_nx, end_nx, take_start, take_end;
    logic      re_sync, re_zc, re_any, do_rst;

    assign mode = esl_mode_e'(mode_i);

    esl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (sync_pin_i),
        .q_o (sync_live)
    );

    assign brk_live = brk_i & brk_in_use(mode);
    assign zc_live  = zc_i;

    always_comb begin
        live_vec           = '0;
        live_vec[IDX_SYNC] = sync_live;
        live_vec[IDX_BRK]  = brk_live;
        live_vec[IDX_ZC]   = zc_live;
    end

    esl_edge #(.W(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .live_i (live_vec),
        .prev_o (prev_vec)
    );

    always_comb begin
        evt.sync_chg = live_vec[IDX_SYNC] ^ prev_vec[IDX_SYNC];
        evt.brk_chg  = live_vec[IDX_BRK]  ^ prev_vec[IDX_BRK];
        evt.zc_rise  = live_vec[IDX_ZC]   & ~prev_vec[IDX_ZC];
        brk_rise     = live_vec[IDX_BRK]  & ~prev_vec[IDX_BRK];
        brk_fall     = ~live_vec[IDX_BRK] &  prev_vec[IDX_BRK];
    end

    esl_brk_store u_brk (
        .clk          (clk),
        .rst          (rst),
        .closed_i     (closed_q),
        .rise_i       (brk_rise),
        .fall_i       (brk_fall),
        .take_start_i (take_start),
        .take_end_i   (take_end),
        .start_o      (start_nx),
        .end_o        (end_nx)
    );

    assign snap_live.sync = sync_live;
    assign snap_live.brk  = brk_live;

    // Events held back by the closure, evaluated at the reset command
    always_comb begin
        zc_seen_nx = zc_seen_q | (closed_q & evt.zc_rise);
        do_rst     = closed_q & rst_latch_i;
        re_sync    = sync_live != snap_q.sync;
        re_zc      = zc_seen_nx & zc_live;
        re_any     = start_nx | end_nx | re_sync | re_zc;
    end

    always_comb begin
        closed_d   = closed_q;
        irq_d      = irq_q;
        snap_d     = snap_q;
        zc_seen_d  = zc_seen_nx;
        take_start = 1'b0;
        take_end   = 1'b0;
        if (!closed_q) begin
            snap_d    = snap_live;
            zc_seen_d = 1'b0;
            if (evt.sync_chg || evt.brk_chg || evt.zc_rise) begin
                closed_d = 1'b1;
                irq_d    = evt_irq(evt, en_sync_i, en_brk_i, en_zc_i);
            end
        end else if (do_rst) begin
            zc_seen_d = 1'b0;
            if (re_any) begin
                snap_d.sync = sync_live;
                snap_d.brk  = start_nx ? 1'b1 : (end_nx ? 1'b0 : brk_live);
                take_start  = start_nx;
                take_end    = !start_nx && end_nx;
                irq_d       = ((start_nx | end_nx) & en_brk_i)
                            | (re_sync & en_sync_i) | (re_zc & en_zc_i);
            end else begin
                closed_d = 1'b0;
                irq_d    = 1'b0;
                snap_d   = snap_live;
            end
        end else begin
            irq_d = irq_q | (evt.brk_chg & en_brk_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            closed_q  <= 1'b0;
            irq_q     <= 1'b0;
            zc_seen_q <= 1'b0;
            snap_q    <= '0;
        end else begin
            closed_q  <= closed_d;
            irq_q     <= irq_d;
            zc_seen_q <= zc_seen_d;
            snap_q    <= snap_d;
        end
    end

    assign stat_sync_o = closed_q ? snap_q.sync : sync_live;
    assign stat_brk_o  = closed_q ? snap_q.brk  : brk_live;
    assign stat_zc_o   = zc_live & en_zc_i;
    assign pend_o      = closed_q;
    assign irq_o       = irq_q;

    // R2: a sync change on an open latch closes it
    a_r2_open_sync_closes: assert property (@(posedge clk) disable iff (rst)
        (!closed_q && evt.sync_chg) |=> pend_o);

    // R2: the frozen sync bit holds until a reset command
    a_r2_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !rst_latch_i) |=> (pend_o && $stable(stat_sync_o)));

    // R11: a request only exists while the latch is closed
    a_r11_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend_o);

    // R8: enabled zero-count rise on an open latch requests service
    a_r8_zc_open_irq: assert property (@(posedge clk) disable iff (rst)
        (!closed_q && evt.zc_rise && en_zc_i) |=> irq_o);

    // R4: break reads 0 in the synchronous modes while open
    a_r4_brk_unused: assert property (@(posedge clk) disable iff (rst)
        (!pend_o && (mode == MODE_EXTSYNC || mode == MODE_INTSYNC)) |-> !stat_brk_o);

endmodule

// File: tb/ext_status_latch_tb_top.sv
module ext_status_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_i;
    logic       sync_pin_i, brk_i, zc_i;
    logic       en_sync_i, en_brk_i, en_zc_i, rst_latch_i;
    logic       stat_sync_o, stat_brk_o, stat_zc_o, pend_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ext_status_latch dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .sync_pin_i  (sync_pin_i),
        .brk_i       (brk_i),
        .zc_i        (zc_i),
        .en_sync_i   (en_sync_i),
        .en_brk_i    (en_brk_i),
        .en_zc_i     (en_zc_i),
        .rst_latch_i (rst_latch_i),
        .stat_sync_o (stat_sync_o),
        .stat_brk_o  (stat_brk_o),
        .stat_zc_o   (stat_zc_o),
        .pend_o      (pend_o),
        .irq_o       (irq_o)
    );

    // {mode[1:0], brk, zc, en_zc}
    localparam logic [4:0] VEC [8] = '{
        5'b00_1_0_0, 5'b01_1_0_0, 5'b10_1_1_0, 5'b11_1_1_1,
        5'b11_0_1_1, 5'b00_0_1_0, 5'b10_0_0_1, 5'b00_1_1_1
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic pulse_rst;
        rst_latch_i = 1'b1;
        tick(1);
        rst_latch_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode_i = 2'b00; sync_pin_i = 0; brk_i = 0; zc_i = 0;
        en_sync_i = 0; en_brk_i = 0; en_zc_i = 0; rst_latch_i = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1", "pend after reset", pend_o, 1'b0);
        chk("R1", "irq after reset", irq_o, 1'b0);
        chk("R1", "sync status after reset", stat_sync_o, 1'b0);

        // Table: R4 break masking, R10 zero-count visibility, R11 reopen
        for (int i = 0; i < 8; i++) begin
            mode_i  = VEC[i][4:3];
            brk_i   = VEC[i][2];
            zc_i    = VEC[i][1];
            en_zc_i = VEC[i][0];
            tick(2);
            pulse_rst();
            tick(1);
            chk("R4", "break status by mode", stat_brk_o,
                VEC[i][2] & (VEC[i][4:3] == 2'b00 || VEC[i][4:3] == 2'b11));
            chk("R10", "zero-count visibility", stat_zc_o, VEC[i][1] & VEC[i][0]);
            chk("R11", "pend after reset command", pend_o, 1'b0);
        end
        mode_i = 2'b00; brk_i = 0; zc_i = 0; en_zc_i = 0;
        tick(2);
        pulse_rst();
        tick(1);

        // R12 / R2: synchronizer latency and closure on a sync change
        en_sync_i  = 1'b1;
        sync_pin_i = 1'b1;
        tick(1);
        chk("R12", "sync after one clock", stat_sync_o, 1'b0);
        tick(1);
        chk("R12", "sync after two clocks", stat_sync_o, 1'b1);
        chk("R2", "not yet closed", pend_o, 1'b0);
        tick(1);
        chk("R2", "closed on sync change", pend_o, 1'b1);
        chk("R2", "irq on enabled sync", irq_o, 1'b1);
        sync_pin_i = 1'b0;
        tick(4);
        chk("R2", "sync frozen while closed", stat_sync_o, 1'b1);
        pulse_rst();
        chk("R3", "odd change re-closes", pend_o, 1'b1);
        chk("R3", "odd change irq", irq_o, 1'b1);
        chk("R3", "new level shown", stat_sync_o, 1'b0);
        pulse_rst();
        chk("R11", "pend cleared", pend_o, 1'b0);
        chk("R11", "irq cleared", irq_o, 1'b0);

        // R3: even number of changes while closed
        sync_pin_i = 1'b1; tick(4);
        sync_pin_i = 1'b0; tick(4);
        sync_pin_i = 1'b1; tick(4);
        pulse_rst();
        chk("R3", "even changes leave latch open", pend_o, 1'b0);

        // R5 / R6: break while closed by a disabled source
        en_sync_i  = 1'b0;
        sync_pin_i = 1'b0;
        tick(4);
        chk("R5", "closed by disabled sync", pend_o, 1'b1);
        chk("R5", "no irq from disabled sync", irq_o, 1'b0);
        en_brk_i = 1'b1;
        brk_i    = 1'b1;
        tick(1);
        chk("R5", "break edge raises irq while closed", irq_o, 1'b1);
        chk("R6", "break still frozen at 0", stat_brk_o, 1'b0);
        pulse_rst();
        chk("R6", "start re-closes", pend_o, 1'b1);
        chk("R6", "start reported as 1", stat_brk_o, 1'b1);
        brk_i = 1'b0;
        tick(2);
        pulse_rst();
        chk("R6", "end re-closes", pend_o, 1'b1);
        chk("R6", "end reported as 0", stat_brk_o, 1'b0);
        chk("R6", "end irq", irq_o, 1'b1);
        pulse_rst();
        chk("R6", "open after end", pend_o, 1'b0);

        // R7: several break sequences in one closure
        en_sync_i  = 1'b1;
        sync_pin_i = 1'b1;
        tick(4);
        brk_i = 1; tick(2); brk_i = 0; tick(2);
        brk_i = 1; tick(2); brk_i = 0; tick(2);
        pulse_rst();
        chk("R7", "first re-close is start", stat_brk_o, 1'b1);
        pulse_rst();
        chk("R7", "second re-close pending", pend_o, 1'b1);
        chk("R7", "second re-close is end", stat_brk_o, 1'b0);
        pulse_rst();
        chk("R7", "no third re-close", pend_o, 1'b0);
        sync_pin_i = 1'b0;
        tick(4);
        brk_i = 1; tick(2); brk_i = 0; tick(2); brk_i = 1; tick(2);
        pulse_rst();
        chk("R7", "start after end reported", stat_brk_o, 1'b1);
        pulse_rst();
        chk("R7", "cancelled end gives no re-close", pend_o, 1'b0);
        brk_i = 0;
        tick(2);
        pulse_rst();
        tick(1);

        // R8: zero count on an open latch, never frozen
        en_sync_i = 0; en_brk_i = 0; en_zc_i = 1;
        zc_i = 1;
        tick(1);
        chk("R8", "zero count closes", pend_o, 1'b1);
        chk("R8", "zero count irq", irq_o, 1'b1);
        chk("R8", "zero count shown", stat_zc_o, 1'b1);
        zc_i = 0;
        tick(1);
        chk("R8", "zero count not held", stat_zc_o, 1'b0);
        pulse_rst();
        chk("R11", "open after zero count", pend_o, 1'b0);

        // R9: zero count during closure
        sync_pin_i = 1'b1;
        tick(4);
        zc_i = 1;
        tick(2);
        chk("R9", "no irq while pending", irq_o, 1'b0);
        pulse_rst();
        chk("R9", "persisting zero count re-closes", pend_o, 1'b1);
        chk("R9", "persisting zero count irq", irq_o, 1'b1);
        pulse_rst();
        chk("R9", "open after zero count service", pend_o, 1'b0);
        zc_i = 0;
        tick(1);
        sync_pin_i = 1'b0;
        tick(4);
        zc_i = 1; tick(2); zc_i = 0; tick(2);
        pulse_rst();
        chk("R9", "expired zero count ignored", pend_o, 1'b0);
        chk("R9", "expired zero count no irq", irq_o, 1'b0);

        // R11: reset command on an open latch
        pulse_rst();
        tick(1);
        chk("R11", "command on open latch pend", pend_o, 1'b0);
        chk("R11", "command on open latch sync", stat_sync_o, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule